// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block produces the timing pulses for one channel of a serial unit that can run asynchronous, clock-synchronous or SPI, smart-card and I2C traffic. An 8-bit divisor register holds N. A 2-bit clock select n sets a prescaler of 4^n. Together they set a base tick whose period is 4^n·(N+1) clock cycles. A phase counter then counts base ticks to mark each bit. The number of base ticks per bit comes from the selected mode, two speed bits and a smart-card cycle count S.

In I2C mode the phase counter also shapes a serial clock that stays low for 16 base ticks and then high for 14. The generator runs while the transmit enable or the receive enable is set. When both enables are clear, every counter is held at zero. The mode, clock select, speed bits and S are captured only while the generator is stopped. A new setting therefore applies from the next start, and a running bit is never disturbed.

Each channel instantiates its own copy, so channels can run at different rates.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor register `div_q` reads 255 (0xFF).
- R2: A write on `wr_en` loads `wr_data` into the divisor at the next edge only when `tx_en` and `rx_en` are both 0. A write while either enable is 1 leaves the divisor unchanged.
- R3: While running, `os_tick` is a one-cycle pulse with period U = 4^n·(N+1) clocks. The first pulse appears U clocks after the first edge at which the generator is running.
- R4: In asynchronous mode (`mode_sel`=0), `bit_tick` pulses once per 32 base ticks when `spd_a` and `spd_b` are both 0. It pulses once per 16 base ticks when exactly one of them is 1, and once per 8 base ticks when both are 1. Every `bit_tick` coincides with an `os_tick`.
- R5: In clock-synchronous/SPI mode (`mode_sel`=1), `bit_tick` pulses once per 4 base ticks.
- R6: In smart-card mode (`mode_sel`=2), `bit_tick` pulses once per 2·S base ticks, and S=0 behaves as S=1.
- R7: In I2C mode (`mode_sel`=3), one serial clock period spans 30 base ticks, with `bit_tick` at its end. `scl_o` is low for the first 16 base ticks and high for the last 14.
- R8: `scl_o` is 1 whenever the generator is stopped or the captured mode is not I2C.
- R9: While `tx_en` and `rx_en` are both 0, no ticks are produced and all counters clear, so a restart begins a fresh bit from count zero.
- R10: `mode_sel`, `clk_sel`, `spd_a`, `spd_b` and `card_s` are captured at every edge while stopped. Changes to them while running have no effect until the generator has stopped and restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; runs the generator |
| rx_en | input | 1 | Receive enable; runs the generator |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | DIV_W (8) | Divisor write value N |
| mode_sel | input | 2 | 0 async, 1 sync/SPI, 2 smart card, 3 I2C |
| clk_sel | input | 2 | Prescaler select n, prescale 4^n |
| spd_a | input | 1 | Async speed bit A (halves ticks per bit) |
| spd_b | input | 1 | Async speed bit B (halves ticks per bit) |
| card_s | input | 10 | Smart-card cycles-per-bit value S |
| div_q | output | DIV_W (8) | Current divisor register value |
| os_tick | output | 1 | Base tick pulse |
| bit_tick | output | 1 | Bit boundary pulse |
| scl_o | output | 1 | I2C serial clock waveform |

## Verification
The hardest condition to reach from the ports is a setting change that arrives in the middle of a running bit. This includes a divisor write attempted while an enable is high. The block must keep the setting it captured at start and ignore the new one. The stimulus changes mode, prescaler and divisor inside a running I2C stretch and then runs on. The reference model keeps its own copy of the captured settings, so any early switch shows up as a tick on the wrong cycle. A brief stop and restart is also placed part-way through a serial clock period, to show that the phase is cleared rather than resumed.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
    parameter int BG_SEL_W = 2;
    parameter int BG_SC_W  = 10;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_CARD  = 2'd2,
        MODE_I2C   = 2'd3
    } bgen_mode_e;

    typedef struct packed {
        bgen_mode_e            mode;
        logic [BG_SEL_W-1:0]   clk_sel;
        logic                  spd_a;
        logic                  spd_b;
        logic [BG_SC_W-1:0]    card_s;
    } bgen_cfg_t;
endpackage

// File: rtl/bgen_div_reg.sv
module bgen_div_reg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_q
);
    logic [DIV_W-1:0] div_d;

    always_comb begin
        div_d = div_q;
        if (wr_en && !busy) begin
            div_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '1;
        end else begin
            div_q <= div_d;
        end
    end

    p_hold_when_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_q));
endmodule

// File: rtl/bgen_cfg_latch.sv
module bgen_cfg_latch
    import bgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  bgen_cfg_t cfg_in,
    output bgen_cfg_t cfg_q
);
    bgen_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (!run) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_ASYNC, clk_sel: '0, spd_a: 1'b0,
                       spd_b: 1'b0, card_s: BG_SC_W'(1)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg_q));
endmodule

// File: rtl/bgen_counter_chain.sv
module bgen_counter_chain
    import bgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  bgen_cfg_t        cfg,
    input  logic [DIV_W-1:0] div_n,
    output logic             os_tick,
    output logic             bit_tick,
    output logic             scl_o
);
    localparam int PRE_W    = 2 * ((1 << BG_SEL_W) - 1);
    localparam int PH_W     = BG_SC_W + 1;
    localparam int I2C_LOW  = 16;
    localparam int I2C_HIGH = 14;
    localparam int I2C_SPAN = I2C_LOW + I2C_HIGH;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph;
        logic             os;
        logic             bt;
        logic             scl;
    } chain_t;

    chain_t           st_d, st_q;
    logic [PRE_W-1:0] pre_lim;
    logic [PH_W-1:0]  ph_lim;
    logic             pre_wrap, unit_hit, bit_hit;

    always_comb begin
        pre_lim = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < 2 * int'(cfg.clk_sel)) begin
                pre_lim[i] = 1'b1;
            end
        end

        case (cfg.mode)
            MODE_ASYNC: begin
                case ({cfg.spd_a, cfg.spd_b})
                    2'b00:   ph_lim = PH_W'(31);
                    2'b11:   ph_lim = PH_W'(7);
                    default: ph_lim = PH_W'(15);
                endcase
            end
            MODE_SYNC: ph_lim = PH_W'(3);
            MODE_CARD: begin
                if (cfg.card_s == '0) begin
                    ph_lim = PH_W'(1);
                end else begin
                    ph_lim = PH_W'({cfg.card_s, 1'b0}) - PH_W'(1);
                end
            end
            default:   ph_lim = PH_W'(I2C_SPAN - 1);
        endcase

        pre_wrap = run && (st_q.pre == pre_lim);
        unit_hit = pre_wrap && (st_q.div == div_n);
        bit_hit  = unit_hit && (st_q.ph == ph_lim);

        st_d = st_q;
        if (!run) begin
            st_d.pre = '0;
            st_d.div = '0;
            st_d.ph  = '0;
        end else begin
            st_d.pre = pre_wrap ? '0 : st_q.pre + PRE_W'(1);
            if (pre_wrap) begin
                st_d.div = unit_hit ? '0 : st_q.div + DIV_W'(1);
            end
            if (unit_hit) begin
                st_d.ph = bit_hit ? '0 : st_q.ph + PH_W'(1);
            end
        end
        st_d.os  = unit_hit;
        st_d.bt  = bit_hit;
        st_d.scl = (run && cfg.mode == MODE_I2C) ? (st_d.ph >= PH_W'(I2C_LOW)) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.scl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign os_tick  = st_q.os;
    assign bit_tick = st_q.bt;
    assign scl_o    = st_q.scl;

    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!os_tick && !bit_tick && st_q.pre == '0 && st_q.div == '0 && st_q.ph == '0));
    p_bit_on_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    p_scl_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || cfg.mode != MODE_I2C) |=> scl_o);
    p_div_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div <= div_n);
    p_phase_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_I2C) |-> (st_q.ph < PH_W'(I2C_SPAN)));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import bgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                wr_en,
    input  logic [DIV_W-1:0]    wr_data,
    input  logic [1:0]          mode_sel,
    input  logic [BG_SEL_W-1:0] clk_sel,
    input  logic                spd_a,
    input  logic                spd_b,
    input  logic [BG_SC_W-1:0]  card_s,
    output logic [DIV_W-1:0]    div_q,
    output logic                os_tick,
    output logic                bit_tick,
    output logic                scl_o
);
    logic      run;
    bgen_cfg_t cfg_in, cfg_q;

    assign run = tx_en | rx_en;

    always_comb begin
        cfg_in.mode    = bgen_mode_e'(mode_sel);
        cfg_in.clk_sel = clk_sel;
        cfg_in.spd_a   = spd_a;
        cfg_in.spd_b   = spd_b;
        cfg_in.card_s  = card_s;
    end

    bgen_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (run),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .div_q   (div_q)
    );

    bgen_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    bgen_counter_chain #(.DIV_W(DIV_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cfg      (cfg_q),
        .div_n    (div_q),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .scl_o    (scl_o)
    );
endmodule

// File: tb/baud_gen_bench.sv
module baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, rx_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode_sel = 2'd0, clk_sel = 2'd0;
    logic       spd_a = 1'b0, spd_b = 1'b0;
    logic [9:0] card_s = 10'd1;
    logic [7:0] div_q;
    logic       os_tick, bit_tick, scl_o;

    int tests = 0, fails = 0, cycles = 0;
    bit checking = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_div = 255, m_mode = 0, m_sel = 0, m_a = 0, m_b = 0, m_s = 1;
    bit m_run = 0, e_os = 0, e_bit = 0, e_scl = 1;

    always #4 clk = ~clk;

    baud_gen u_baud_gen (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .wr_en(wr_en),
        .wr_data(wr_data), .mode_sel(mode_sel), .clk_sel(clk_sel), .spd_a(spd_a),
        .spd_b(spd_b), .card_s(card_s), .div_q(div_q), .os_tick(os_tick),
        .bit_tick(bit_tick), .scl_o(scl_o)
    );

    function automatic int ticks_per_bit();
        case (m_mode)
            0: return (m_a + m_b == 0) ? 32 : ((m_a + m_b == 1) ? 16 : 8);
            1: return 4;
            2: return (m_s == 0) ? 2 : 2 * m_s;
            default: return 30;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_div = 255; m_mode = 0; m_sel = 0; m_a = 0; m_b = 0; m_s = 1;
            e_os = 0; e_bit = 0; e_scl = 1; m_run = 0;
        end else begin
            m_run = tx_en || rx_en;
            if (!m_run) begin
                m_cnt = 0; m_mode = mode_sel; m_sel = clk_sel;
                m_a = spd_a; m_b = spd_b; m_s = card_s;
                if (wr_en) m_div = wr_data;
                e_os = 0; e_bit = 0; e_scl = 1;
            end else begin
                int u, k;
                m_cnt++;
                u = (4 ** m_sel) * (m_div + 1);
                k = ticks_per_bit();
                e_os  = (m_cnt % u) == 0;
                e_bit = (m_cnt % (u * k)) == 0;
                e_scl = (m_mode == 3) ? (((m_cnt / u) % k) >= 16) : 1'b1;
            end
        end
    end

    task automatic check(string req, string what, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d (cycle %0d)", req, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) begin
            check(cur_req, "os_tick", os_tick, e_os);
            check(cur_req, "bit_tick", bit_tick, e_bit);
            check((m_run && m_mode == 3) ? cur_req : "R8", "scl_o", scl_o, e_scl);
            check(cur_req, "div_q", div_q, m_div);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(int mode, int sel, int a, int b, int s, int n);
        @(negedge clk);
        tx_en = 0; rx_en = 0;
        mode_sel = 2'(mode); clk_sel = 2'(sel); spd_a = 1'(a); spd_b = 1'(b); card_s = 10'(s);
        wr_en = 1; wr_data = 8'(n);
        @(negedge clk);
        wr_en = 0;
        cyc(2);
    endtask

    task automatic run_for(bit t, bit r, int n);
        tx_en = t; rx_en = r;
        cyc(n);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        checking = 1'b1;
        cyc(1);
        cur_req = "R1";
        check("R1", "div_q after reset", div_q, 255);
        check("R1", "scl_o after reset", scl_o, 1);

        cur_req = "R3";                       // default N=255, prescale 1
        run_for(1, 0, 600);
        cur_req = "R9";
        run_for(0, 0, 4);

        cur_req = "R4";
        setup(0, 0, 0, 0, 1, 0);  run_for(0, 1, 100);
        setup(0, 1, 1, 0, 1, 2);  run_for(1, 1, 500);
        setup(0, 1, 0, 1, 1, 0);  run_for(1, 0, 200);
        setup(0, 0, 1, 1, 1, 4);  run_for(1, 0, 200);

        cur_req = "R5";
        setup(1, 2, 0, 0, 1, 1);  run_for(0, 1, 400);

        cur_req = "R6";
        setup(2, 0, 0, 0, 5, 1);  run_for(1, 0, 100);
        setup(2, 0, 0, 0, 0, 0);  run_for(1, 0, 30);

        cur_req = "R7";
        setup(3, 0, 0, 0, 1, 1);  run_for(1, 0, 200);
        setup(3, 1, 0, 0, 1, 0);  run_for(0, 1, 300);

        // R10 and R2: settings and a divisor write arrive mid-run
        cur_req = "R10";
        setup(3, 0, 0, 0, 1, 1);
        run_for(1, 0, 37);
        mode_sel = 2'd0; clk_sel = 2'd3; spd_a = 1; card_s = 10'd7;
        wr_en = 1; wr_data = 8'd9;
        cyc(1);
        wr_en = 0;
        cyc(150);
        cur_req = "R2";
        run_for(0, 0, 1);
        cyc(1);
        check("R2", "divisor after busy write", div_q, 1);
        wr_en = 1; wr_data = 8'd3;
        cyc(1);
        wr_en = 0;
        cyc(1);
        check("R2", "divisor after idle write", div_q, 3);

        // R10: new settings take effect after restart (async, n=3, one speed bit)
        cur_req = "R10";
        run_for(1, 0, 600);

        // R9: short stop part-way through an I2C period restarts from zero
        cur_req = "R9";
        setup(3, 0, 0, 0, 1, 1);
        run_for(1, 0, 45);
        run_for(0, 0, 1);
        run_for(0, 1, 130);
        run_for(0, 0, 3);
        check("R8", "scl_o stopped", scl_o, 1);
        check("R9", "os_tick stopped", os_tick, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule